// File: doc/BRIEF.md
# Message-Signalled Interrupt Generator

This block sits on the device side of a PCI Express function. It holds the message-signalled interrupt capability registers: control, message address (low and high words), message data, per-vector mask and per-vector pending. It turns single-cycle event pulses from the device's internal logic into memory write requests. Each request carries the programmed address and the programmed 16-bit data. The low bits of the data are replaced by the number of the vector that fired. No interrupt pin is used while the block is enabled, and the block drives an output that switches the legacy INTx pin off.

An event on a masked vector is kept as a pending bit. It is sent later, once the vector is unmasked. An interrupt write must not overtake data writes that the device posted earlier. The block therefore counts data writes that the posted path has accepted but not yet sent. When it selects a vector, it takes a snapshot of that count and waits until that many writes have been sent.

A small state machine issues the writes. It has three states:
- `ST_IDLE` waits for a vector that can be served. On the transition *take* it selects the lowest such vector, latches the address and data, and loads the drain count.
- `ST_DRAIN` waits for the earlier data writes. On the transition *drained* (drain count zero) it moves to `ST_SEND`. On the transition *abort* (the block is no longer active) it drops the request and returns to `ST_IDLE`.
- `ST_SEND` holds the request valid. On the transition *accepted* (ready high) it returns to `ST_IDLE`.

Top module: `msi_gen`

## Requirements
- R1: After reset the enable bit is 0, all supported mask bits are set (0xFF when 8 vectors are supported), pending reads 0, `req_valid` is 0 and `intx_off` is 0.
- R2: The control word is at `cfg_idx` 0 and has these fields:
  - bit 0: enable (read/write)
  - bits 3:1: log2 of the vectors supported (read-only, `VEC_LOG2`)
  - bits 6:4: log2 of the vectors enabled
  - bit 7: 64-bit address capable (read-only)
  - bit 8: per-vector masking capable (read-only)

  The other registers, by `cfg_idx`: 1 is address low; 2 is address high; 3 is data; 4 is mask; 5 is pending (read-only). With a 32-bit address only, data, mask and pending move down one index.
- R3: A value written to the enabled-count field that is above the supported value reads back as the supported value.
- R4: A request drives `req_addr` = {address high, address low} and `req_data` = the programmed data with its low (enabled log2) bits replaced by the vector index. `req_valid`, the address and the data stay stable until `req_ready`, and each handshake carries one interrupt.
- R5: An event on a masked vector sets that vector's bit in the pending register, and no write is issued. Clearing the mask bit then issues exactly one write and clears the pending bit.
- R6: A write is not issued until every data write counted by `dw_acc` before the vector was selected has been reported by `dw_sent`.
- R7: While the enable bit is 0 or `msix_en` is 1, events are dropped: no write is issued and no pending bit is set.
- R8: `intx_off` follows the enable bit.
- R9: Vectors that are ready in the same cycle are served one per handshake, lowest index first.
- R10: With nothing outstanding and the vector unmasked, `req_valid` rises after the third rising edge, counting the edge that samples the event.
- R11: An event on a vector at or above the enabled count is ignored.
- R12: Address low bits 1:0 always read and send as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 3 | Configuration register index (dwords) |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data for `cfg_idx` (combinational) |
| event_in | input | NVEC | One event pulse per vector |
| msix_en | input | 1 | Companion MSI-X enable; blocks all messages |
| dw_acc | input | 1 | A posted data write was accepted |
| dw_sent | input | 1 | A posted data write was sent |
| req_valid | output | 1 | Interrupt write request valid |
| req_ready | input | 1 | Interrupt write request accepted |
| req_addr | output | 64 | Interrupt write address |
| req_data | output | 16 | Interrupt write data |
| intx_off | output | 1 | Disables the legacy INTx pin |

## Verification
An event is stored in the pending register at the edge that samples it. The state machine takes the vector at the next edge. `req_valid` is high after the edge after that, so the basic test checks the outputs at the falling edges after each of those three rising edges.

Configuration writes take effect at one rising edge. Unmasking or a final `dw_sent` therefore shows up as `req_valid` two edges later. The tests wait a bounded number of falling edges for that result.

Checks that expect no message watch `req_valid` at every falling edge over a window longer than this latency. They then read the pending register through the configuration port.

// File: rtl/msi_pkg.sv
package msi_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DRAIN = 2'd1,
        ST_SEND  = 2'd2
    } msi_state_e;

    localparam int CFG_IDX_W = 3;
endpackage

// File: rtl/msi_cfg_regs.sv
module msi_cfg_regs #(
    parameter int VEC_LOG2 = 3,
    parameter bit ADDR64   = 1'b1,
    parameter bit MASK_CAP = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_we,
    input  logic [2:0]  cfg_idx,
    input  logic [31:0] cfg_wdata,
    input  logic [31:0] pend_in,
    output logic [31:0] cfg_rdata,
    output logic        msi_en,
    output logic [2:0]  mme,
    output logic [63:0] base_addr,
    output logic [15:0] base_data,
    output logic [(1<<VEC_LOG2)-1:0] vec_mask
);
    localparam int NVEC = 1 << VEC_LOG2;
    localparam logic [2:0] CAP      = 3'(VEC_LOG2);
    localparam logic [2:0] IDX_DATA = ADDR64 ? 3'd3 : 3'd2;
    localparam logic [2:0] IDX_MASK = IDX_DATA + 3'd1;
    localparam logic [2:0] IDX_PEND = IDX_DATA + 3'd2;

    logic            en_q;
    logic [2:0]      mme_q;
    logic [31:2]     alo_q;
    logic [31:0]     ahi_q;
    logic [15:0]     data_q;
    logic [NVEC-1:0] mask_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            mme_q  <= 3'd0;
            alo_q  <= '0;
            ahi_q  <= '0;
            data_q <= '0;
            mask_q <= MASK_CAP ? '1 : '0;
        end else if (cfg_we) begin
            if (cfg_idx == 3'd0) begin
                en_q  <= cfg_wdata[0];
                mme_q <= (cfg_wdata[6:4] > CAP) ? CAP : cfg_wdata[6:4];
            end else if (cfg_idx == 3'd1) begin
                alo_q <= cfg_wdata[31:2];
            end else if (ADDR64 && cfg_idx == 3'd2) begin
                ahi_q <= cfg_wdata;
            end else if (cfg_idx == IDX_DATA) begin
                data_q <= cfg_wdata[15:0];
            end else if (MASK_CAP && cfg_idx == IDX_MASK) begin
                mask_q <= cfg_wdata[NVEC-1:0];
            end
        end
    end

    always_comb begin
        cfg_rdata = '0;
        if (cfg_idx == 3'd0)
            cfg_rdata = {23'h0, MASK_CAP, ADDR64, mme_q, CAP, en_q};
        else if (cfg_idx == 3'd1)
            cfg_rdata = {alo_q, 2'b00};
        else if (ADDR64 && cfg_idx == 3'd2)
            cfg_rdata = ahi_q;
        else if (cfg_idx == IDX_DATA)
            cfg_rdata = {16'h0, data_q};
        else if (MASK_CAP && cfg_idx == IDX_MASK)
            cfg_rdata = 32'(mask_q);
        else if (MASK_CAP && cfg_idx == IDX_PEND)
            cfg_rdata = pend_in;
    end

    assign msi_en    = en_q;
    assign mme       = mme_q;
    assign base_addr = {(ADDR64 ? ahi_q : 32'h0), alo_q, 2'b00};
    assign base_data = data_q;
    assign vec_mask  = MASK_CAP ? mask_q : '0;

    // R3: the enabled-count field never exceeds the capable count
    a_r3_mme_clamped: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_idx == 3'd0 && cfg_wdata[6:4] > CAP) |=> (mme == CAP));
endmodule

// File: rtl/msi_vec_arb.sv
module msi_vec_arb #(
    parameter int NVEC = 8,
    parameter int IW   = 3
) (
    input  logic [NVEC-1:0] req,
    output logic            vld,
    output logic [IW-1:0]   idx
);
    always_comb begin
        vld = |req;
        idx = '0;
        for (int k = NVEC - 1; k >= 0; k--) begin
            if (req[k]) idx = IW'(k);
        end
    end
endmodule

// File: rtl/msi_req_fsm.sv
module msi_req_fsm
    import msi_pkg::*;
#(
    parameter int IW    = 3,
    parameter int OUT_W = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          active,
    input  logic          grant_vld,
    input  logic [IW-1:0] grant_idx,
    input  logic [2:0]    mme,
    input  logic [63:0]   base_addr,
    input  logic [15:0]   base_data,
    input  logic          dw_acc,
    input  logic          dw_sent,
    input  logic          req_ready,
    output logic          take,
    output logic          req_valid,
    output logic [63:0]   req_addr,
    output logic [15:0]   req_data
);
    msi_state_e       state_q, state_d;
    logic [OUT_W-1:0] out_q, drain_q;
    logic [63:0]      addr_q;
    logic [15:0]      data_q;
    logic [15:0]      low_mask, composed;

    assign take     = (state_q == ST_IDLE) && active && grant_vld;
    assign low_mask = 16'((17'd1 << mme) - 17'd1);
    assign composed = (base_data & ~low_mask) | (16'(grant_idx) & low_mask);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (take) state_d = ST_DRAIN;
            ST_DRAIN: if (!active) state_d = ST_IDLE;
                      else if (drain_q == '0) state_d = ST_SEND;
            ST_SEND:  if (req_ready) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q   <= '0;
            drain_q <= '0;
            addr_q  <= '0;
            data_q  <= '0;
        end else begin
            out_q <= out_q + OUT_W'(dw_acc) - OUT_W'(dw_sent);
            if (take) begin
                drain_q <= out_q - OUT_W'(dw_sent);
                addr_q  <= base_addr;
                data_q  <= composed;
            end else if (state_q == ST_DRAIN && drain_q != '0) begin
                drain_q <= drain_q - OUT_W'(dw_sent);
            end
        end
    end

    always_comb begin
        req_valid = (state_q == ST_SEND);
        req_addr  = addr_q;
        req_data  = data_q;
    end

    // R4: the request is held unchanged until it is accepted
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) && $stable(req_data)));
    // R6: the posted path never reports more sends than acceptances
    a_r6_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        (dw_sent && !dw_acc) |-> (out_q != '0));
    // R7: an inactive block starts no request
    a_r7_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !active) |=> !req_valid);
endmodule

// File: rtl/msi_gen.sv
module msi_gen #(
    parameter int VEC_LOG2 = 3,
    parameter bit ADDR64   = 1'b1,
    parameter bit MASK_CAP = 1'b1,
    parameter int OUT_W    = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_we,
    input  logic [2:0]               cfg_idx,
    input  logic [31:0]              cfg_wdata,
    output logic [31:0]              cfg_rdata,
    input  logic [(1<<VEC_LOG2)-1:0] event_in,
    input  logic                     msix_en,
    input  logic                     dw_acc,
    input  logic                     dw_sent,
    output logic                     req_valid,
    input  logic                     req_ready,
    output logic [63:0]              req_addr,
    output logic [15:0]              req_data,
    output logic                     intx_off
);
    localparam int NVEC = 1 << VEC_LOG2;
    localparam int IW   = (VEC_LOG2 > 0) ? VEC_LOG2 : 1;

    logic            msi_en, active, take, grant_vld;
    logic [2:0]      mme;
    logic [63:0]     base_addr;
    logic [15:0]     base_data;
    logic [NVEC-1:0] vec_mask, pend_q, in_range, serve, clr;
    logic [IW-1:0]   grant_idx;

    msi_cfg_regs #(.VEC_LOG2(VEC_LOG2), .ADDR64(ADDR64), .MASK_CAP(MASK_CAP)) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_wdata(cfg_wdata), .pend_in(32'(pend_q)), .cfg_rdata(cfg_rdata),
        .msi_en(msi_en), .mme(mme), .base_addr(base_addr),
        .base_data(base_data), .vec_mask(vec_mask)
    );

    assign active   = msi_en && !msix_en;
    assign intx_off = msi_en;

    always_comb begin
        for (int k = 0; k < NVEC; k++) in_range[k] = ((32'(k) >> mme) == 32'd0);
    end

    assign serve = pend_q & ~vec_mask & in_range;
    assign clr   = take ? (NVEC'(1) << grant_idx) : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & ~clr) | (event_in & in_range & {NVEC{active}});
    end

    msi_vec_arb #(.NVEC(NVEC), .IW(IW)) u_arb (
        .req(serve), .vld(grant_vld), .idx(grant_idx)
    );

    msi_req_fsm #(.IW(IW), .OUT_W(OUT_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .active(active), .grant_vld(grant_vld),
        .grant_idx(grant_idx), .mme(mme), .base_addr(base_addr),
        .base_data(base_data), .dw_acc(dw_acc), .dw_sent(dw_sent),
        .req_ready(req_ready), .take(take), .req_valid(req_valid),
        .req_addr(req_addr), .req_data(req_data)
    );

    // R5: a masked vector is never taken, and a taken vector was pending
    a_r5_masked: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> (!vec_mask[grant_idx] && pend_q[grant_idx]));
    // R9: no lower-index vector is waiting when one is taken
    a_r9_lowest_first: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> ((serve & ((NVEC'(1) << grant_idx) - NVEC'(1))) == '0));
    // R8: a request only starts while the legacy pin is switched off
    a_r8_intx_off: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_valid) |-> intx_off);
endmodule

// File: tb/msi_gen_test.sv
`timescale 1ns/1ps
module msi_gen_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_idx = 3'd0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic [7:0]  event_in = '0;
    logic        msix_en = 1'b0, dw_acc = 1'b0, dw_sent = 1'b0;
    logic        req_valid, req_ready = 1'b1, intx_off;
    logic [63:0] req_addr;
    logic [15:0] req_data;
    int nchk = 0, nfail = 0;
    bit finished = 0;

    localparam logic [63:0] ADDR = 64'h0000_0001_FEE0_1000;

    always #10 clk = ~clk;

    msi_gen uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .event_in(event_in),
        .msix_en(msix_en), .dw_acc(dw_acc), .dw_sent(dw_sent),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_data(req_data), .intx_off(intx_off)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [2:0] idx, input logic [31:0] val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = idx; cfg_wdata = val;
        @(posedge clk);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic cfg_read(input logic [2:0] idx, output logic [31:0] val);
        cfg_idx = idx;
        #1 val = cfg_rdata;
    endtask

    task automatic fire(input logic [7:0] vecs);
        @(negedge clk);
        event_in = vecs;
        @(posedge clk);
        @(negedge clk);
        event_in = '0;
    endtask

    task automatic expect_msg(input string tag, input logic [15:0] data, input int tmo);
        bit got = 0;
        for (int i = 0; i < tmo && !got; i++) begin
            @(negedge clk);
            if (req_valid) got = 1;
        end
        chk({tag, " valid"}, 64'(got), 64'd1);
        if (got) begin
            chk({tag, " addr"}, req_addr, ADDR);
            chk({tag, " data"}, 64'(req_data), 64'(data));
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic expect_none(input string tag, input int n);
        bit seen = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (req_valid) seen = 1;
        end
        chk(tag, 64'(seen), 64'd0);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        @(negedge clk);
        chk("R1 req_valid", 64'(req_valid), 64'd0);
        chk("R1 R8 intx_off", 64'(intx_off), 64'd0);
        cfg_read(3'd0, v); chk("R1 R2 ctrl", 64'(v), 64'h186);
        cfg_read(3'd4, v); chk("R1 mask", 64'(v), 64'hFF);
        cfg_read(3'd5, v); chk("R1 pending", 64'(v), 64'h0);
    endtask

    task automatic t_cfg();
        logic [31:0] v;
        cfg_write(3'd1, 32'hFEE0_1003);
        cfg_write(3'd2, 32'h0000_0001);
        cfg_write(3'd3, 32'h0000_4A30);
        cfg_write(3'd0, 32'h0000_0071);
        cfg_read(3'd0, v); chk("R3 clamp", 64'(v), 64'h1B7);
        cfg_read(3'd1, v); chk("R12 addr low", 64'(v), 64'hFEE0_1000);
        cfg_read(3'd2, v); chk("R2 addr high", 64'(v), 64'h1);
        cfg_read(3'd3, v); chk("R2 data", 64'(v), 64'h4A30);
        chk("R8 intx_off on", 64'(intx_off), 64'd1);
        cfg_write(3'd4, 32'h0);
        cfg_read(3'd4, v); chk("R2 mask clear", 64'(v), 64'h0);
    endtask

    task automatic t_latency();
        @(negedge clk);
        event_in = 8'h01;
        @(posedge clk);
        @(negedge clk);
        event_in = '0;
        chk("R10 edge1", 64'(req_valid), 64'd0);
        @(posedge clk); @(negedge clk);
        chk("R10 edge2", 64'(req_valid), 64'd0);
        @(posedge clk); @(negedge clk);
        chk("R10 edge3", 64'(req_valid), 64'd1);
        chk("R4 addr", req_addr, ADDR);
        chk("R4 data vec0", 64'(req_data), 64'h4A30);
        @(posedge clk); @(negedge clk);
        chk("R4 one per handshake", 64'(req_valid), 64'd0);
    endtask

    task automatic t_vector();
        fire(8'h20);
        expect_msg("R4 vec5", 16'h4A35, 6);
    endtask

    task automatic t_priority();
        fire(8'h44);
        expect_msg("R9 first vec2", 16'h4A32, 6);
        expect_msg("R9 second vec6", 16'h4A36, 6);
        expect_none("R9 no third", 8);
    endtask

    task automatic t_mask();
        logic [31:0] v;
        cfg_write(3'd4, 32'h08);
        fire(8'h08);
        expect_none("R5 masked quiet", 8);
        cfg_read(3'd5, v); chk("R5 pending set", 64'(v), 64'h08);
        cfg_write(3'd4, 32'h0);
        expect_msg("R5 unmask sends", 16'h4A33, 6);
        cfg_read(3'd5, v); chk("R5 pending cleared", 64'(v), 64'h0);
        expect_none("R5 single write", 8);
    endtask

    task automatic t_hold();
        logic [15:0] d0;
        bit bad = 0;
        req_ready = 1'b0;
        fire(8'h02);
        @(negedge clk); @(negedge clk);
        chk("R4 hold valid", 64'(req_valid), 64'd1);
        d0 = req_data;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            if (!req_valid || req_data !== d0 || req_addr !== ADDR) bad = 1;
        end
        chk("R4 held stable", 64'(bad), 64'd0);
        chk("R4 hold data", 64'(d0), 64'h4A31);
        req_ready = 1'b1;
        @(posedge clk); @(negedge clk);
        chk("R4 released", 64'(req_valid), 64'd0);
    endtask

    task automatic t_order();
        @(negedge clk);
        dw_acc = 1'b1;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        dw_acc = 1'b0;
        event_in = 8'h01;
        @(posedge clk); @(negedge clk);
        event_in = '0;
        expect_none("R6 waits for two sends", 6);
        dw_sent = 1'b1;
        @(posedge clk); @(negedge clk);
        dw_sent = 1'b0;
        expect_none("R6 waits for last send", 5);
        dw_sent = 1'b1;
        @(posedge clk); @(negedge clk);
        dw_sent = 1'b0;
        chk("R6 not before drain edge", 64'(req_valid), 64'd0);
        expect_msg("R6 after drain", 16'h4A30, 3);
    endtask

    task automatic t_range();
        logic [31:0] v;
        cfg_write(3'd0, 32'h0000_0011);
        fire(8'h10);
        expect_none("R11 out of range", 8);
        cfg_read(3'd5, v); chk("R11 no pending", 64'(v), 64'h0);
        fire(8'h02);
        expect_msg("R11 R4 one low bit", 16'h4A31, 6);
        cfg_write(3'd0, 32'h0000_0031);
    endtask

    task automatic t_inactive();
        logic [31:0] v;
        msix_en = 1'b1;
        fire(8'h01);
        expect_none("R7 msix blocks", 10);
        cfg_read(3'd5, v); chk("R7 no pending msix", 64'(v), 64'h0);
        msix_en = 1'b0;
        cfg_write(3'd0, 32'h0000_0030);
        chk("R8 intx_off off", 64'(intx_off), 64'd0);
        fire(8'h01);
        expect_none("R7 disabled quiet", 10);
        cfg_read(3'd5, v); chk("R7 no pending off", 64'(v), 64'h0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_cfg();
        t_latency();
        t_vector();
        t_priority();
        t_mask();
        t_hold();
        t_order();
        t_range();
        t_inactive();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end

    initial begin
        #(20 * 100000);
        if (!finished) begin
            finished = 1;
            nchk++;
            nfail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end
endmodule